// File: doc/BRIEF.md
# Per-stream input sampling delay

This block sits at the receive edge of a serial stream switch. It moves the point where each of several serial input lines is sampled to later than the frame pulse. The step is half a period of the internal master clock, and each line has its own setting. Every input line has a nominal sampling instant once per bit period, counted from the frame pulse. The offset chosen for a line moves that instant forward by 0 to 9 half-periods. An odd number of half-periods puts the sample on the falling clock edge and an even number puts it on the rising edge. Lines at the slowest rate keep their nominal instant whatever offset is programmed.

The offsets come from a bank of configuration words, four offset fields to a word. A value written into a word is only picked up at the next frame pulse, so every bit of one frame is taken with one offset. When a line's offset changes at a pulse, any capture from the old frame that has not yet been delivered is discarded, so two captures never meet on the output.

Each line has a valid strobe and a data bit. The strobe is high for one clock in the cycle that carries a freshly captured bit. A serial line cannot be stalled, so there is no ready input and no back-pressure: the consumer must take the bit in the cycle its strobe is high.

Top module: `sdo_input_aligner`

## Requirements
- R1: The clock cycle in which `frame_pulse` is high has phase index 0. The index then counts up by one per cycle, modulo 8, until the next pulse. A line with rate code 3, 2, 1 or 0 has its nominal instant at the rising edges whose index is a multiple of 1, 2, 4 or 8 respectively.
- R2: The offset field of line s is bits [4(s mod 4)+3 : 4(s mod 4)] of configuration word s/4. Word w occupies `cfg_words[16w+15 : 16w]`.
- R3: With an even effective offset 2k, the bit is sampled at the rising edge k cycles after the nominal edge. Strobe and data are visible right after that same edge.
- R4: With an odd effective offset 2k+1, the bit is sampled at the falling edge in the cycle k cycles after the nominal edge. It is delivered at the following rising edge.
- R5: Field codes 10 to 15 act as 9 half-periods.
- R6: A line with rate code 0 (the slowest rate) is sampled at its nominal edge whatever its field holds.
- R7: The offset a line uses is the field value captured at the most recent frame pulse. A field change between pulses has no effect until the next pulse.
- R8: If a line's field differs from its active offset at a frame pulse, its earlier-frame captures not yet delivered at that edge are dropped. If the field is unchanged, no capture is lost.
- R9: While reset is asserted all strobes are low. Reset leaves every active offset at 0 and the phase counter so that the first cycle after release has index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal master clock; both edges used |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_pulse | input | 1 | High for one cycle at each frame boundary |
| cfg_words | input | NUM_STREAMS/STREAMS_PER_WORD*STREAMS_PER_WORD*FIELD_W | Packed offset configuration words |
| rate_sel | input | 2*NUM_STREAMS | Per-line rate code (0 slowest .. 3 fastest) |
| ser_in | input | NUM_STREAMS | Serial input lines |
| bit_valid | output | NUM_STREAMS | One-cycle strobe per captured bit |
| bit_data | output | NUM_STREAMS | Captured bit, valid while strobe is high |

## Verification
The bench builds the block with its default parameters: 32 lines, four 4-bit fields per word and a limit of 9 half-periods. With these values every code from 0 to 15 can be driven, so the saturating codes and the deepest odd delay of 4.5 cycles are exercised, and all four rate codes appear side by side across eight words. Frame lengths of 8 to 40 cycles let a 4.5-cycle delay run past a frame pulse, which brings the flush-on-change rule and the lossless unchanged case within reach.

// File: rtl/sdo_pkg.sv
`timescale 1ns/1ps
package sdo_pkg;
  localparam int RATE_W    = 2;
  localparam int SLOW_DIV  = 8;
  localparam int PHASE_W   = $clog2(SLOW_DIV);

  typedef enum logic [RATE_W-1:0] {
    RATE_X1 = 2'd0,   // slowest, never shifted
    RATE_X2 = 2'd1,
    RATE_X4 = 2'd2,
    RATE_X8 = 2'd3
  } rate_e;

  // Phase bits that must be zero for a nominal sampling edge.
  function automatic logic [PHASE_W-1:0] tick_mask(input logic [RATE_W-1:0] r);
    case (r)
      RATE_X1: tick_mask = PHASE_W'(SLOW_DIV - 1);
      RATE_X2: tick_mask = PHASE_W'(SLOW_DIV / 2 - 1);
      RATE_X4: tick_mask = PHASE_W'(SLOW_DIV / 4 - 1);
      default: tick_mask = '0;
    endcase
  endfunction
endpackage

// File: rtl/sdo_tick_gen.sv
`timescale 1ns/1ps
module sdo_tick_gen
  import sdo_pkg::*;
#(
  parameter int NUM_STREAMS = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frame_pulse,
  input  logic [NUM_STREAMS*RATE_W-1:0] rate_sel,
  output logic [NUM_STREAMS-1:0]        nominal
);
  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] phase_d;

  assign phase_d = frame_pulse ? '0 : phase_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '1;
    else        phase_q <= phase_d;
  end

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_tick
    assign nominal[s] = (phase_d & tick_mask(rate_sel[s*RATE_W +: RATE_W])) == '0;
  end
endmodule

// File: rtl/sdo_offset_bank.sv
`timescale 1ns/1ps
module sdo_offset_bank
  import sdo_pkg::*;
#(
  parameter int NUM_STREAMS = 32,
  parameter int FIELD_W     = 4,
  parameter int MAX_HALF    = 9
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           frame_pulse,
  input  logic [NUM_STREAMS*FIELD_W-1:0] field_flat,
  input  logic [NUM_STREAMS*RATE_W-1:0]  rate_sel,
  output logic [NUM_STREAMS*FIELD_W-1:0] half_cnt,
  output logic [NUM_STREAMS*FIELD_W-1:0] act_flat,
  output logic [NUM_STREAMS-1:0]         flush
);
  localparam logic [FIELD_W-1:0] LIMIT = FIELD_W'(MAX_HALF);

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_slot
    logic [FIELD_W-1:0] field;
    logic [FIELD_W-1:0] act_q;
    logic [FIELD_W-1:0] eff;
    logic [FIELD_W-1:0] clamped;

    assign field   = field_flat[s*FIELD_W +: FIELD_W];
    assign eff     = frame_pulse ? field : act_q;
    assign clamped = (eff > LIMIT) ? LIMIT : eff;
    assign flush[s] = frame_pulse && (field != act_q);
    assign half_cnt[s*FIELD_W +: FIELD_W] =
      (rate_sel[s*RATE_W +: RATE_W] == RATE_X1) ? '0 : clamped;
    assign act_flat[s*FIELD_W +: FIELD_W] = act_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           act_q <= '0;
      else if (frame_pulse) act_q <= field;
    end
  end
endmodule

// File: rtl/sdo_lane.sv
`timescale 1ns/1ps
module sdo_lane #(
  parameter int FIELD_W  = 4,
  parameter int MAX_HALF = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nominal,
  input  logic               flush,
  input  logic [FIELD_W-1:0] half_cnt,
  input  logic               sdi,
  output logic               stb,
  output logic               dat
);
  localparam int WHOLE = (MAX_HALF / 2 < 1) ? 1 : MAX_HALF / 2;
  localparam int K_W   = FIELD_W - 1;

  logic [K_W-1:0]   whole_k;
  logic             odd_h;
  logic [WHOLE-1:0] rise_q, rise_d;   // rising-edge captures due in j+1 cycles
  logic [WHOLE:0]   fall_q, fall_d;   // falling-edge captures due in j cycles
  logic             rise_hit;
  logic             fall_stb, fall_bit;

  assign whole_k = half_cnt[FIELD_W-1:1];
  assign odd_h   = half_cnt[0];

  for (genvar j = 0; j < WHOLE; j++) begin : g_rise
    if (j + 1 < WHOLE) begin : g_chain
      assign rise_d[j] = (rise_q[j+1] && !flush) ||
                         (nominal && !odd_h && whole_k == K_W'(j + 1));
    end else begin : g_tail
      assign rise_d[j] = nominal && !odd_h && whole_k == K_W'(j + 1);
    end
  end

  for (genvar j = 0; j <= WHOLE; j++) begin : g_fall
    if (j < WHOLE) begin : g_chain
      assign fall_d[j] = (fall_q[j+1] && !flush) ||
                         (nominal && odd_h && whole_k == K_W'(j));
    end else begin : g_tail
      assign fall_d[j] = nominal && odd_h && whole_k == K_W'(j);
    end
  end

  assign rise_hit = (rise_q[0] && !flush) || (nominal && !odd_h && whole_k == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
      stb    <= 1'b0;
      dat    <= 1'b0;
    end else begin
      rise_q <= rise_d;
      fall_q <= fall_d;
      stb    <= rise_hit || (fall_stb && !flush);
      dat    <= rise_hit ? sdi : fall_bit;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_stb <= 1'b0;
      fall_bit <= 1'b0;
    end else begin
      fall_stb <= fall_q[0];
      if (fall_q[0]) fall_bit <= sdi;
    end
  end
endmodule

// File: rtl/sdo_input_aligner.sv
`timescale 1ns/1ps
module sdo_input_aligner
  import sdo_pkg::*;
#(
  parameter int NUM_STREAMS      = 32,
  parameter int STREAMS_PER_WORD = 4,
  parameter int FIELD_W          = 4,
  parameter int MAX_HALF         = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_pulse,
  input  logic [NUM_STREAMS/STREAMS_PER_WORD*STREAMS_PER_WORD*FIELD_W-1:0] cfg_words,
  input  logic [NUM_STREAMS*RATE_W-1:0] rate_sel,
  input  logic [NUM_STREAMS-1:0]        ser_in,
  output logic [NUM_STREAMS-1:0]        bit_valid,
  output logic [NUM_STREAMS-1:0]        bit_data
);
  localparam int NUM_WORDS = NUM_STREAMS / STREAMS_PER_WORD;
  localparam int WORD_W    = STREAMS_PER_WORD * FIELD_W;

  logic [NUM_STREAMS*FIELD_W-1:0] field_vec;
  logic [NUM_STREAMS*FIELD_W-1:0] half_vec;
  logic [NUM_STREAMS*FIELD_W-1:0] act_vec;
  logic [NUM_STREAMS-1:0]         nominal_vec;
  logic [NUM_STREAMS-1:0]         flush_vec;

  // Unpack each word into its per-line fields.
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    for (genvar i = 0; i < STREAMS_PER_WORD; i++) begin : g_field
      assign field_vec[(w*STREAMS_PER_WORD+i)*FIELD_W +: FIELD_W] =
        cfg_words[w*WORD_W + i*FIELD_W +: FIELD_W];
    end
  end

  sdo_tick_gen #(.NUM_STREAMS(NUM_STREAMS)) u_tick (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
    .rate_sel(rate_sel), .nominal(nominal_vec)
  );

  sdo_offset_bank #(
    .NUM_STREAMS(NUM_STREAMS), .FIELD_W(FIELD_W), .MAX_HALF(MAX_HALF)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
    .field_flat(field_vec), .rate_sel(rate_sel),
    .half_cnt(half_vec), .act_flat(act_vec), .flush(flush_vec)
  );

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_lane
    sdo_lane #(.FIELD_W(FIELD_W), .MAX_HALF(MAX_HALF)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .nominal(nominal_vec[s]), .flush(flush_vec[s]),
      .half_cnt(half_vec[s*FIELD_W +: FIELD_W]),
      .sdi(ser_in[s]), .stb(bit_valid[s]), .dat(bit_data[s])
    );
  end
endmodule

// File: rtl/sdo_checker.sv
`timescale 1ns/1ps
module sdo_checker
  import sdo_pkg::*;
#(
  parameter int NUM_STREAMS = 32,
  parameter int FIELD_W     = 4,
  parameter int MAX_HALF    = 9
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           frame_pulse,
  input logic [NUM_STREAMS*RATE_W-1:0]  rate_sel,
  input logic [NUM_STREAMS-1:0]         nominal,
  input logic [NUM_STREAMS*FIELD_W-1:0] half_cnt,
  input logic [NUM_STREAMS*FIELD_W-1:0] act_flat,
  input logic [NUM_STREAMS-1:0]         bit_valid
);
  // Every line has a nominal edge in the pulse cycle.
  assert_pulse_ticks_all_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |-> (&nominal));

  // Active offsets only move on a frame pulse.
  assert_offset_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_pulse |=> $stable(act_flat));

  // Strobes are quiet while reset is held.
  always @(posedge clk) begin
    if (!rst_n) assert_reset_quiet_R9: assert (bit_valid == '0);
  end

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_chk
    assert_half_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      half_cnt[s*FIELD_W +: FIELD_W] <= FIELD_W'(MAX_HALF));

    assert_slow_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_sel[s*RATE_W +: RATE_W] == RATE_X1) |-> (half_cnt[s*FIELD_W +: FIELD_W] == '0));
  end
endmodule

bind sdo_input_aligner sdo_checker #(
  .NUM_STREAMS(NUM_STREAMS), .FIELD_W(FIELD_W), .MAX_HALF(MAX_HALF)
) u_sdo_checker (
  .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .rate_sel(rate_sel),
  .nominal(nominal_vec), .half_cnt(half_vec), .act_flat(act_vec),
  .bit_valid(bit_valid)
);

// File: tb/test_sdo_input_aligner.sv
`timescale 1ns/1ps
module test_sdo_input_aligner;
  localparam int N   = 32;
  localparam int SPW = 4;
  localparam int FW  = 4;
  localparam int T   = 240;
  localparam int TE  = T + 8;

  logic clk = 1'b0, rst_n = 1'b0, frame_pulse = 1'b0;
  logic [N*FW-1:0] cfg_words = '0;
  logic [2*N-1:0]  rate_sel = '0;
  logic [N-1:0]    ser_in = '0;
  logic [N-1:0]    bit_valid, bit_data;

  logic [N-1:0]    hv   [0:2*TE+1];
  logic            fp_a [0:TE];
  logic [N*FW-1:0] cfg_a[0:TE];
  logic [N-1:0]    es   [0:TE];
  logic [N-1:0]    eb   [0:TE];

  int checks = 0, fails = 0;

  sdo_input_aligner #(.NUM_STREAMS(N), .STREAMS_PER_WORD(SPW), .FIELD_W(FW), .MAX_HALF(9))
    i_sdo_input_aligner (
      .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .cfg_words(cfg_words),
      .rate_sel(rate_sel), .ser_in(ser_in), .bit_valid(bit_valid), .bit_data(bit_data));

  always #5 clk = ~clk;

  function automatic int mask_of(input int r);
    case (r) 0: return 7; 1: return 3; 2: return 1; default: return 0; endcase
  endfunction

  function automatic int pick_code(input int mode);
    case (mode)
      0: return 0;
      1: return 2 * ($urandom % 5);
      2: return 2 * ($urandom % 5) + 1;
      3: return 10 + ($urandom % 6);
      default: return $urandom % 16;
    endcase
  endfunction

  // Stimulus and expected outputs derived from the requirements.
  task automatic build(input int mode, input int flen);
    int cnt; int pos; int r; int eff; int k; int f;
    logic [FW-1:0] act [N];
    logic [N*FW-1:0] cur;
    for (int t = 0; t <= TE; t++) begin es[t] = '0; eb[t] = '0; end
    for (int h = 0; h <= 2*TE+1; h++) hv[h] = $urandom;
    cur = '0;
    for (int t = 0; t <= TE; t++) begin
      fp_a[t] = (t % flen) == 0;
      if (t == 0) begin
        for (int s = 0; s < N; s++) cur[s*FW +: FW] = FW'(pick_code(mode));
      end else if (mode == 5 && !fp_a[t] && ($urandom % 6) == 0) begin
        f = $urandom % N; cur[f*FW +: FW] = FW'(pick_code(mode));
      end else if (mode == 6 && fp_a[t] && ($urandom % 2) == 0) begin
        for (int s = 0; s < N; s++) cur[s*FW +: FW] = FW'(pick_code(mode));
      end else if ((mode == 4 || mode == 7) && ($urandom % 10) == 0) begin
        f = $urandom % N; cur[f*FW +: FW] = FW'(pick_code(mode));
      end
      cfg_a[t] = cur;
    end
    cnt = 7;
    for (int s = 0; s < N; s++) act[s] = '0;
    for (int t = 0; t < T; t++) begin
      pos = fp_a[t] ? 0 : (cnt + 1) % 8;
      cnt = pos;
      for (int s = 0; s < N; s++) begin
        if (fp_a[t]) begin
          if (cfg_a[t][s*FW +: FW] != act[s])
            for (int j = 0; j < 6; j++) es[t+j][s] = 1'b0;   // R8 flush
          act[s] = cfg_a[t][s*FW +: FW];
        end
        r = int'(rate_sel[2*s +: 2]);
        eff = (r == 0) ? 0 : ((act[s] > 9) ? 9 : int'(act[s]));
        if ((pos & mask_of(r)) == 0) begin
          k = eff / 2;
          if (eff % 2 == 0) begin
            es[t+k][s] = 1'b1; eb[t+k][s] = hv[2*(t+k)][s];
          end else begin
            es[t+k+1][s] = 1'b1; eb[t+k+1][s] = hv[2*(t+k)+1][s];
          end
        end
      end
    end
  endtask

  task automatic check(input bit ok, input string tag, input int t,
                       input logic [N-1:0] av, input logic [N-1:0] ev,
                       input logic [N-1:0] ab, input logic [N-1:0] xb);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: valid %h (exp %h) data %h (exp %h)", tag, t, av, ev, ab, xb);
    end
  endtask

  task automatic run_phase(input int mode, input int flen, input string tag);
    rst_n = 1'b0; frame_pulse = 1'b0; ser_in = '0;
    for (int s = 0; s < N; s++) begin
      case (mode)
        0: rate_sel[2*s +: 2] = 2'(s % 4);
        1: rate_sel[2*s +: 2] = 2'd3;
        2: rate_sel[2*s +: 2] = 2'(s % 3 + 1);
        3: rate_sel[2*s +: 2] = (s < 16) ? 2'd3 : 2'd2;
        4: rate_sel[2*s +: 2] = 2'd0;
        5: rate_sel[2*s +: 2] = 2'($urandom % 3 + 1);
        6: rate_sel[2*s +: 2] = 2'($urandom % 4);
        default: rate_sel[2*s +: 2] = (s < 16) ? 2'd1 : 2'd2;
      endcase
    end
    build(mode, flen);
    repeat (2) @(posedge clk);
    #1 check(bit_valid == '0, "R9 reset", -1, bit_valid, '0, bit_data, '0);
    @(negedge clk); #2.5;
    rst_n = 1'b1;
    for (int t = 0; t < T; t++) begin
      frame_pulse = fp_a[t]; cfg_words = cfg_a[t]; ser_in = hv[2*t];
      @(posedge clk); #1;
      check((bit_valid == es[t]) && ((bit_data & es[t]) == (eb[t] & es[t])),
            tag, t, bit_valid, es[t], bit_data & es[t], eb[t] & es[t]);
      #1.5 ser_in = hv[2*t+1];
      #5;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    run_phase(0, 16, "R1 nominal edges");
    run_phase(1, 24, "R3 even offsets");
    run_phase(2, 16, "R4 odd offsets");
    run_phase(3, 8,  "R5 saturating codes");
    run_phase(4, 16, "R6 slowest rate bypass");
    run_phase(5, 40, "R7 mid-frame writes");
    run_phase(6, 8,  "R8 changes at pulse");
    run_phase(7, 24, "R2 field layout, mixed groups");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: run did not end (exp completion)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule